// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is the controller side of a bus that carries data and timing over one open-drain wire. It never drives the wire high: it only pulls it low or lets go, and an external pull-up returns the wire to its high idle level. Each bit is a timed time slot. A short low pulse followed by release writes a one. A long low pulse writes a zero. A short low pulse followed by a sample of the released wire reads a bit. A long low pulse followed by a listening window resets the bus and finds out whether any device answers with a presence pulse.

A host picks an operation with a three-bit code and pulses a start strobe while the block is idle. The block raises a busy flag and times the whole operation from its own clock. Its time base is a microsecond counter that restarts at every slot. The byte operations run eight slots back to back, least significant bit first. The presence result and the read data are held until the next operation of the same kind. The incoming wire level passes through a synchronizer before it is sampled.

Top module: `swm_bus_master`

## Requirements
- R1: After reset `busy`, `bus_drive_low`, `presence` and `rd_data` are all 0, and the wire is released whenever the block is idle.
- R2: Operation code 1 (bus reset) pulls the wire low for 480 us and then releases it.
- R3: During a bus reset, the wire is sampled 70 us after release, and `presence` becomes 1 if the wire is low there and 0 otherwise. `busy` stays high for 960 us in total, and `presence` changes at no other time.
- R4: Operation code 2 writes `wr_data[0]` in one slot. The low pulse lasts 6 us for a one and 60 us for a zero. `busy` lasts 70 us, which is a 65 us slot plus 5 us of recovery.
- R5: Operation code 3 reads one bit. It pulls the wire low for 6 us, samples the released wire 15 us after the slot start, and returns the level in `rd_data[0]` with `rd_data[7:1]` cleared.
- R6: Operation code 4 writes `wr_data` as eight consecutive write slots, bit 0 first, with `busy` held for 560 us.
- R7: Operation code 5 reads eight consecutive read slots. The first sampled level goes into `rd_data[0]` and the last into `rd_data[7]`.
- R8: A start strobe while `busy` is high is ignored, including in the final busy cycle. Codes 0, 6 and 7 start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, CLKS_PER_US cycles per microsecond |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | 1 bus reset, 2 write bit, 3 read bit, 4 write byte, 5 read byte |
| start | input | 1 | Launches `op_code` when idle |
| wr_data | input | 8 | Data for the write operations, captured at start |
| bus_line | input | 1 | Sensed level of the open-drain wire |
| bus_drive_low | output | 1 | 1 enables the pull-down on the wire |
| busy | output | 1 | High for the whole operation, including the last recovery time |
| presence | output | 1 | Result of the latest bus reset |
| rd_data | output | 8 | Result of the latest read operation |

## Verification
The two events that can share one cycle are the end of an operation and a new start strobe. The bench raises `start` with a different operation code in the very last cycle in which `busy` is high. It then checks that `busy` drops at the expected cycle, stays low afterwards, and that no extra low pulse appears on the wire. A second strobe in the middle of the same operation must not change its pulse width or its length.

// File: rtl/swm_pkg.sv
package swm_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_RESET = 3'd1,
    OP_WBIT  = 3'd2,
    OP_RBIT  = 3'd3,
    OP_WBYTE = 3'd4,
    OP_RBYTE = 3'd5
  } swm_op_e;

  // codes outside 1..5 launch nothing
  function automatic logic op_known(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

  function automatic logic op_reads(input swm_op_e op);
    return (op == OP_RBIT) || (op == OP_RBYTE);
  endfunction

  function automatic logic op_bytewide(input swm_op_e op);
    return (op == OP_WBYTE) || (op == OP_RBYTE);
  endfunction

  // length of the low pulse that opens a slot, in microseconds
  function automatic int unsigned low_span_us(input swm_op_e op, input logic bit_val,
                                              input int unsigned rst_low,
                                              input int unsigned w0_low,
                                              input int unsigned w1_low,
                                              input int unsigned rd_low);
    case (op)
      OP_RESET:          return rst_low;
      OP_WBIT, OP_WBYTE: return bit_val ? w1_low : w0_low;
      OP_RBIT, OP_RBYTE: return rd_low;
      default:           return 0;
    endcase
  endfunction

endpackage

// File: rtl/swm_line_sync.sv
module swm_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  logic [STAGES-1:0] sh_q;

  // wire idles high, so the chain resets to ones
  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], line_in};
  end

  assign line_out = sh_q[STAGES-1];
endmodule

// File: rtl/swm_us_timer.sv
module swm_us_timer #(
  parameter int unsigned CLKS_PER_US = 250,
  parameter int unsigned UW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  output logic [UW-1:0] us_cnt,
  output logic          on_edge,
  output logic          us_tick
);
  localparam int unsigned PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);

  logic [PW-1:0] pre_q;

  assign on_edge = (pre_q == '0);
  assign us_tick = run && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_q  <= '0;
      us_cnt <= '0;
    end else if (run) begin
      if (pre_q == PRE_LAST) begin
        pre_q  <= '0;
        us_cnt <= us_cnt + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // a restarted slot begins at an exact microsecond boundary
  assert_restart_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (us_cnt == '0) && on_edge);
endmodule

// File: rtl/swm_bus_master.sv
module swm_bus_master
  import swm_pkg::*;
#(
  parameter int unsigned CLKS_PER_US  = 250,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RST_LOW_US   = 480,
  parameter int unsigned PRES_WAIT_US = 70,
  parameter int unsigned RST_TAIL_US  = 410,
  parameter int unsigned SLOT_US      = 65,
  parameter int unsigned RECOVER_US   = 5,
  parameter int unsigned W1_LOW_US    = 6,
  parameter int unsigned W0_LOW_US    = 60,
  parameter int unsigned RD_LOW_US    = 6,
  parameter int unsigned RD_SAMPLE_US = 15,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic              start,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bus_line,
  output logic              bus_drive_low,
  output logic              busy,
  output logic              presence,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned RST_TOTAL = RST_LOW_US + PRES_WAIT_US + RST_TAIL_US;
  localparam int unsigned BIT_TOTAL = SLOT_US + RECOVER_US;
  localparam int unsigned MAX_TOTAL = (RST_TOTAL > BIT_TOTAL) ? RST_TOTAL : BIT_TOTAL;
  localparam int unsigned UW        = $clog2(MAX_TOTAL + 1);
  localparam int unsigned IW        = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  swm_op_e           op_q;
  logic              busy_q, pres_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] wr_q, rd_q;

  logic [UW-1:0] us_cnt, low_us, end_us, samp_us;
  logic          on_edge, us_tick, line_s;
  swm_op_e       op_in;

  // named events, shared by the sequencer and the assertions
  logic accept, slot_done, last_slot, op_finish, next_slot, sample_evt, cur_bit;

  swm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(bus_line), .line_out(line_s));

  swm_us_timer #(.CLKS_PER_US(CLKS_PER_US), .UW(UW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(accept || next_slot), .run(busy_q),
    .us_cnt(us_cnt), .on_edge(on_edge), .us_tick(us_tick));

  assign op_in   = swm_op_e'(op_code);
  assign cur_bit = wr_q[idx_q];
  assign low_us  = UW'(low_span_us(op_q, cur_bit, RST_LOW_US, W0_LOW_US, W1_LOW_US, RD_LOW_US));
  assign end_us  = (op_q == OP_RESET) ? UW'(RST_TOTAL) : UW'(BIT_TOTAL);
  assign samp_us = (op_q == OP_RESET) ? UW'(RST_LOW_US + PRES_WAIT_US) : UW'(RD_SAMPLE_US);

  assign accept     = start && !busy_q && op_known(op_code);
  assign slot_done  = busy_q && us_tick && (us_cnt == end_us - UW'(1));
  assign last_slot  = !op_bytewide(op_q) || (idx_q == IW'(DATA_W - 1));
  assign op_finish  = slot_done && last_slot;
  assign next_slot  = slot_done && !last_slot;
  assign sample_evt = busy_q && on_edge && (us_cnt == samp_us) &&
                      ((op_q == OP_RESET) || op_reads(op_q));

  assign bus_drive_low = busy_q && (us_cnt < low_us);
  assign busy          = busy_q;
  assign presence      = pres_q;
  assign rd_data       = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      idx_q  <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      pres_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= op_in;
      idx_q  <= '0;
      wr_q   <= wr_data;
      if (op_reads(op_in))     rd_q   <= '0;
      if (op_in == OP_RESET)   pres_q <= 1'b0;
    end else begin
      if (op_finish) busy_q <= 1'b0;
      if (next_slot) idx_q  <= idx_q + 1'b1;
      if (sample_evt) begin
        if (op_q == OP_RESET) pres_q      <= !line_s;
        else                  rd_q[idx_q] <= line_s;
      end
    end
  end

  // ---- assertions ----
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !op_finish |=> busy_q && (op_q == $past(op_q)));

  assert_presence_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !(sample_evt && (op_q == OP_RESET)) |=> $stable(pres_q));

  assert_low_starts_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive_low) |-> (us_cnt == '0) && on_edge);

  assert_sample_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !bus_drive_low);

  assert_byte_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    next_slot |=> busy_q && (idx_q == IW'($past(idx_q) + 1'b1)));

  assert_finish_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_finish |=> !busy_q && !bus_drive_low);
endmodule

// File: tb/swm_bus_master_bench.sv
module swm_bus_master_bench;
  localparam int CPU = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] op = '0;
  logic       start = 1'b0;
  logic [7:0] wdat = '0;
  logic       drv, busy, pres;
  logic [7:0] rdat;
  logic       s_pres = 1'b0, s_rd = 1'b0;
  wire        line = !(drv || s_pres || s_rd);

  swm_bus_master #(.CLKS_PER_US(CPU)) u_swm_bus_master (
    .clk(clk), .rst_n(rst_n), .op_code(op), .start(start), .wr_data(wdat),
    .bus_line(line), .bus_drive_low(drv), .busy(busy), .presence(pres), .rd_data(rdat));

  int total = 0, bad = 0;
  int widths[32];
  int nw = 0, run_len = 0;
  bit pres_en = 0, rd_en = 0, done = 0;
  logic [7:0] rd_bits = '0;
  int rd_idx = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // low pulse widths in clock cycles
  always @(negedge clk) begin
    if (drv) run_len++;
    else if (run_len > 0) begin
      if (nw < 32) widths[nw] = run_len;
      nw++;
      run_len = 0;
    end
  end

  // device model: presence pulse 15 us after release, 120 us long
  always @(negedge drv) if (pres_en) begin
    repeat (15*CPU) @(negedge clk);
    s_pres = 1'b1;
    repeat (120*CPU) @(negedge clk);
    s_pres = 1'b0;
  end

  // device model: a zero bit holds the wire low for 30 us from slot start
  always @(posedge drv) if (rd_en) begin
    logic b;
    b = rd_bits[rd_idx];
    rd_idx++;
    if (!b) begin
      s_rd = 1'b1;
      repeat (30*CPU) @(negedge clk);
      s_rd = 1'b0;
    end
  end

  task automatic launch(input logic [2:0] c, input logic [7:0] d, output int cyc);
    nw = 0;
    @(negedge clk);
    op = c; wdat = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R1", "busy", busy, 0);
    chk("R1", "drive", drv, 0);
    chk("R1", "presence", pres, 0);
    chk("R1", "rd_data", rdat, 0);
  endtask

  task automatic t_bus_reset(input bit answer);
    int cyc;
    pres_en = answer;
    launch(3'd1, 8'h00, cyc);
    pres_en = 0;
    chk("R2", "pulse count", nw, 1);
    chk("R2", "low width", widths[0], 480*CPU);
    chk("R3", "busy cycles", cyc, 960*CPU);
    chk("R3", "presence", pres, int'(answer));
    chk("R1", "released when idle", drv, 0);
  endtask

  task automatic t_write_bit(input logic b);
    int cyc;
    launch(3'd2, {7'b0, b}, cyc);
    chk("R4", "pulse count", nw, 1);
    chk("R4", "low width", widths[0], (b ? 6 : 60)*CPU);
    chk("R4", "busy cycles", cyc, 70*CPU);
  endtask

  task automatic t_read_bit(input logic b, input logic [7:0] exp);
    int cyc;
    rd_bits = {7'b0, b}; rd_idx = 0; rd_en = 1;
    launch(3'd3, 8'h00, cyc);
    rd_en = 0;
    chk("R5", "low width", widths[0], 6*CPU);
    chk("R5", "rd_data", rdat, exp);
    chk("R5", "busy cycles", cyc, 70*CPU);
  endtask

  task automatic t_write_byte(input logic [7:0] d);
    int cyc;
    launch(3'd4, d, cyc);
    chk("R6", "pulse count", nw, 8);
    for (int i = 0; i < 8; i++) chk("R6", $sformatf("bit%0d width", i), widths[i], (d[i] ? 6 : 60)*CPU);
    chk("R6", "busy cycles", cyc, 8*70*CPU);
  endtask

  task automatic t_read_byte(input logic [7:0] d);
    int cyc;
    rd_bits = d; rd_idx = 0; rd_en = 1;
    launch(3'd5, 8'hFF, cyc);
    rd_en = 0;
    chk("R7", "pulse count", nw, 8);
    chk("R7", "rd_data", rdat, d);
    chk("R7", "busy cycles", cyc, 8*70*CPU);
  endtask

  // strobes mid-operation and in the last busy cycle
  task automatic t_start_while_busy;
    int cyc;
    nw = 0;
    @(negedge clk);
    op = 3'd2; wdat = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      if (cyc == 100) begin op = 3'd1; start = 1'b1; end
      else if (cyc == 101) start = 1'b0;
      else if (cyc == 70*CPU) begin op = 3'd3; start = 1'b1; end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8", "busy cycles", cyc, 70*CPU);
    chk("R8", "busy after last-cycle strobe", busy, 0);
    repeat (20) @(negedge clk);
    chk("R8", "still idle", busy, 0);
    chk("R8", "single pulse", nw, 1);
    chk("R8", "pulse width", widths[0], 6*CPU);
  endtask

  task automatic t_bad_codes;
    logic [2:0] codes[3] = '{3'd0, 3'd6, 3'd7};
    for (int k = 0; k < 3; k++) begin
      nw = 0;
      @(negedge clk);
      op = codes[k]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8", $sformatf("busy for code %0d", codes[k]), busy, 0);
      repeat (3) @(negedge clk);
      chk("R8", $sformatf("no pulse for code %0d", codes[k]), nw + int'(drv), 0);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_bus_reset(1'b1);
    t_bus_reset(1'b0);
    t_write_bit(1'b1);
    t_write_bit(1'b0);
    t_read_bit(1'b1, 8'h01);
    t_read_bit(1'b0, 8'h00);
    t_write_byte(8'hA6);
    t_read_byte(8'h5C);
    t_start_while_busy();
    t_bad_codes();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule